// File: doc/BRIEF.md
# Next-PC Branch Prediction Unit

This block sits beside the instruction fetch path and proposes, every cycle, the address to fetch after the current one. It looks up the fetch address in three structures at once. The first is a direction table of two-bit counters, indexed by mixing PC bits with a global outcome history. The second is a direct-mapped target buffer of branch destinations. The third is a circular return stack that is fed by call indications from decode. One combinational selection merges the three results into a single next-PC and a taken flag.

Training uses one resolution port. The execute stage reports a branch address, whether the branch went, and where it went. That single report steps the counter state machine, shifts the global history and, for taken branches, fills the target buffer. Calls push their return address. Returns pop it and redirect fetch to it. Both stack actions happen only on a valid fetch.

Each direction entry is a four-state machine: `CTR_STRONG_NT` (0), `CTR_WEAK_NT` (1), `CTR_WEAK_T` (2), `CTR_STRONG_T` (3). A taken report moves it one state up, a not-taken report one state down, and it stays put at either end. The stack runs its own operation decoder with the operations `RAS_IDLE`, `RAS_PUSH` and `RAS_POP`. The top chooses among the selections `SEL_SEQ`, `SEL_BTB` and `SEL_RAS`.

Top module: `nextpc_predictor`

## Requirements
- R1: After reset every direction entry is `CTR_WEAK_NT`, the target buffer holds no valid entry, the return stack is empty and the history is zero, so any fetch address predicts not taken with next PC equal to fetch address + 4.
- R2: Direction entries saturate: a taken report at `CTR_STRONG_T` stays there, a not-taken report at `CTR_STRONG_NT` stays there, otherwise they move one state up or down. The predicted direction is taken in `CTR_WEAK_T` and `CTR_STRONG_T`.
- R3: The direction index is `pc[HIST_BITS+1:2] XOR history`. This is used for both lookup and training. Each resolution report shifts its outcome into bit 0 of the history, after training with the old history.
- R4: The target buffer is direct-mapped on `pc[BTB_IDX_BITS+1:2]` with tag `pc[XLEN-1:BTB_IDX_BITS+2]`. Every taken report writes tag and target at its index. A not-taken report leaves it unchanged.
- R5: For a non-return fetch, next PC is the buffered target when the direction is taken and the buffer hits. It is fetch address + 4 when the direction is not taken or the buffer misses. The taken flag follows the direction counter.
- R6: A valid fetch with the call flag set pushes the supplied return address. When the return flag is set without the call flag and the stack is not empty, next PC is the top entry with the taken flag high. A valid fetch in that case pops the entry. Call takes precedence when both flags are set.
- R7: The stack holds `RAS_DEPTH` entries. A push onto a full stack overwrites the oldest entry, so later pops return the newest `RAS_DEPTH` addresses in reverse order.
- R8: A return on an empty stack predicts fetch address + 4 with the taken flag low and leaves the stack empty.
- R9: With `fetch_valid` low, call and return flags change no stack state, though the prediction outputs are still driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Current fetch address is real; enables stack updates |
| fetch_pc | input | XLEN | Address being fetched |
| is_call | input | 1 | Fetched instruction is a call |
| is_ret | input | 1 | Fetched instruction is a return |
| call_ret_addr | input | XLEN | Return address to push for a call |
| upd_valid | input | 1 | Resolution report present |
| upd_pc | input | XLEN | Address of the resolved branch |
| upd_taken | input | 1 | Branch was actually taken |
| upd_target | input | XLEN | Resolved branch destination |
| pred_next_pc | output | XLEN | Predicted next fetch address |
| pred_taken | output | 1 | Predicted direction / redirect flag |

## Verification
Directed scenarios drive the resolution port with loop-shaped outcome streams (several taken, then one exit), long runs of one outcome that drive counters into both saturation states, and two branches that collide in one target-buffer slot. The first separates history-mixed indexing from plain PC indexing. The second exposes wrapping counters. The third distinguishes tag comparison and taken-only filling from unconditional writes. Call/return sequences cover nested LIFO order, overflow beyond the stack depth, pops on an empty stack and flags raised with an invalid fetch. Together they show circular overwrite, the empty fallback and the fetch-valid gating. A reference model in the bench tracks counters, history, buffer and stack, and is compared after every step.

// File: rtl/nxp_pkg.sv
package nxp_pkg;

    // Two-bit direction counter states; the numeric order is the counting order.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_e;

    // Return stack operation chosen in a cycle.
    typedef enum logic [1:0] {
        RAS_IDLE = 2'd0,
        RAS_PUSH = 2'd1,
        RAS_POP  = 2'd2
    } ras_op_e;

    // Source of the next-PC prediction.
    typedef enum logic [1:0] {
        SEL_SEQ = 2'd0,
        SEL_BTB = 2'd1,
        SEL_RAS = 2'd2
    } sel_e;

    // Counter transition: saturating step toward the resolved outcome.
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_WEAK_NT;
        endcase
        return nxt;
    endfunction

    // Direction implied by a counter state.
    function automatic logic ctr_says_taken(input ctr_e cur);
        logic t;
        unique case (cur)
            CTR_STRONG_NT, CTR_WEAK_NT: t = 1'b0;
            CTR_WEAK_T, CTR_STRONG_T:   t = 1'b1;
            default:                    t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/gshare_dir.sv
module gshare_dir
    import nxp_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int HIST_BITS = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            upd_valid,
    input  logic [XLEN-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int ENTRIES = 1 << HIST_BITS;

    ctr_e                 tbl [ENTRIES];
    logic [HIST_BITS-1:0] ghr;
    logic [HIST_BITS-1:0] lk_idx;
    logic [HIST_BITS-1:0] up_idx;
    ctr_e                 lk_state;
    ctr_e                 up_state;

    // Hashed index: PC word bits mixed with global history.
    assign lk_idx   = lk_pc[HIST_BITS+1:2] ^ ghr;
    assign up_idx   = upd_pc[HIST_BITS+1:2] ^ ghr;
    assign lk_state = tbl[lk_idx];
    assign up_state = tbl[up_idx];

    // State register process: one counter stepped per resolution report.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl[i] <= CTR_WEAK_NT;
            end
            ghr <= '0;
        end else if (upd_valid) begin
            tbl[up_idx] <= ctr_step(up_state, upd_taken);
            ghr         <= {ghr[HIST_BITS-2:0], upd_taken};
        end
    end

    // Output process.
    always_comb begin
        lk_taken = ctr_says_taken(lk_state);
    end

    // R3: newest outcome lands in history bit 0.
    p_hist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghr[0] == $past(upd_taken)));

    // R2: saturation at the top end.
    p_sat_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && up_state == CTR_STRONG_T)
        |=> (tbl[$past(up_idx)] == CTR_STRONG_T));

    // R2: saturation at the bottom end.
    p_sat_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && up_state == CTR_STRONG_NT)
        |=> (tbl[$past(up_idx)] == CTR_STRONG_NT));

    // R3: history holds when no report arrives.
    p_hist_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr));

endmodule

// File: rtl/btb_dm.sv
module btb_dm #(
    parameter int XLEN     = 32,
    parameter int IDX_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] lk_pc,
    output logic            lk_hit,
    output logic [XLEN-1:0] lk_target,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_pc,
    input  logic [XLEN-1:0] wr_target
);

    localparam int ENTRIES = 1 << IDX_BITS;
    localparam int TAG_W   = XLEN - IDX_BITS - 2;

    logic              vld  [ENTRIES];
    logic [TAG_W-1:0]  tags [ENTRIES];
    logic [XLEN-1:0]   tgts [ENTRIES];

    logic [IDX_BITS-1:0] lk_idx;
    logic [IDX_BITS-1:0] wr_idx;
    logic [TAG_W-1:0]    lk_tag;
    logic [TAG_W-1:0]    wr_tag;

    assign lk_idx = lk_pc[IDX_BITS+1:2];
    assign lk_tag = lk_pc[XLEN-1:IDX_BITS+2];
    assign wr_idx = wr_pc[IDX_BITS+1:2];
    assign wr_tag = wr_pc[XLEN-1:IDX_BITS+2];

    // Valid bits carry reset; payload does not need it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld[i] <= 1'b0;
            end
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx] <= wr_tag;
            tgts[wr_idx] <= wr_target;
        end
    end

    always_comb begin
        lk_hit    = vld[lk_idx] && (tags[lk_idx] == lk_tag);
        lk_target = tgts[lk_idx];
    end

    // R4: a fill makes that slot match the written address next cycle.
    p_fill_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld[$past(wr_idx)] && tags[$past(wr_idx)] == $past(wr_tag)
                   && tgts[$past(wr_idx)] == $past(wr_target)));

endmodule

// File: rtl/ras_circ.sv
module ras_circ
    import nxp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [XLEN-1:0] push_data,
    output logic [XLEN-1:0] top_data,
    output logic            empty
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [XLEN-1:0] mem [DEPTH];
    logic [PW-1:0]   top_ptr;
    logic [CW-1:0]   count;
    ras_op_e         op;

    // Operation decode: push wins; pop needs an entry.
    always_comb begin
        if (push)                op = RAS_PUSH;
        else if (pop && !empty)  op = RAS_POP;
        else                     op = RAS_IDLE;
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_ptr <= '0;
            count   <= '0;
        end else begin
            unique case (op)
                RAS_PUSH: begin
                    top_ptr <= top_ptr + PW'(1);
                    if (count != FULL_CNT) count <= count + CW'(1);
                end
                RAS_POP: begin
                    top_ptr <= top_ptr - PW'(1);
                    count   <= count - CW'(1);
                end
                RAS_IDLE: begin
                    top_ptr <= top_ptr;
                    count   <= count;
                end
                default: begin
                    top_ptr <= top_ptr;
                    count   <= count;
                end
            endcase
        end
    end

    // Storage: a push onto a full stack reuses the oldest slot.
    always_ff @(posedge clk) begin
        if (op == RAS_PUSH) mem[top_ptr] <= push_data;
    end

    // Output process.
    always_comb begin
        empty    = (count == '0);
        top_data = mem[top_ptr - PW'(1)];
    end

    // R7: occupancy never exceeds the depth.
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R6: a pushed address is visible on top next cycle.
    p_push_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (top_data == $past(push_data)));

    // R8: popping an empty stack leaves it empty.
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty);

endmodule

// File: rtl/nextpc_predictor.sv
module nextpc_predictor
    import nxp_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int HIST_BITS    = 6,
    parameter int BTB_IDX_BITS = 4,
    parameter int RAS_DEPTH    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_pc,
    input  logic            is_call,
    input  logic            is_ret,
    input  logic [XLEN-1:0] call_ret_addr,
    input  logic            upd_valid,
    input  logic [XLEN-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [XLEN-1:0] upd_target,
    output logic [XLEN-1:0] pred_next_pc,
    output logic            pred_taken
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic            dir_taken;
    logic            btb_hit;
    logic [XLEN-1:0] btb_target;
    logic [XLEN-1:0] ras_top;
    logic            ras_empty;
    logic            ras_push;
    logic            ras_pop;
    logic            ret_only;
    logic [XLEN-1:0] seq_pc;
    sel_e            sel;

    gshare_dir #(
        .XLEN      (XLEN),
        .HIST_BITS (HIST_BITS)
    ) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_taken  (dir_taken),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_taken (upd_taken)
    );

    btb_dm #(
        .XLEN     (XLEN),
        .IDX_BITS (BTB_IDX_BITS)
    ) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_hit    (btb_hit),
        .lk_target (btb_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_pc     (upd_pc),
        .wr_target (upd_target)
    );

    assign ret_only = is_ret && !is_call;
    assign ras_push = fetch_valid && is_call;
    assign ras_pop  = fetch_valid && ret_only;

    ras_circ #(
        .XLEN  (XLEN),
        .DEPTH (RAS_DEPTH)
    ) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ras_push),
        .pop       (ras_pop),
        .push_data (call_ret_addr),
        .top_data  (ras_top),
        .empty     (ras_empty)
    );

    assign seq_pc = fetch_pc + STEP;

    // Source selection.
    always_comb begin
        if (ret_only) begin
            sel = ras_empty ? SEL_SEQ : SEL_RAS;
        end else if (dir_taken && btb_hit) begin
            sel = SEL_BTB;
        end else begin
            sel = SEL_SEQ;
        end
    end

    // Output process.
    always_comb begin
        unique case (sel)
            SEL_RAS: begin
                pred_next_pc = ras_top;
                pred_taken   = 1'b1;
            end
            SEL_BTB: begin
                pred_next_pc = btb_target;
                pred_taken   = 1'b1;
            end
            SEL_SEQ: begin
                pred_next_pc = seq_pc;
                pred_taken   = ret_only ? 1'b0 : dir_taken;
            end
            default: begin
                pred_next_pc = seq_pc;
                pred_taken   = 1'b0;
            end
        endcase
    end

    // R5: a non-return fetch that misses the buffer falls through sequentially.
    p_miss_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_only && !btb_hit) |-> (pred_next_pc == fetch_pc + STEP));

    // R8: a return on an empty stack never redirects.
    p_ret_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_only && ras_empty) |-> (!pred_taken && pred_next_pc == fetch_pc + STEP));

    // R9: stack contents hold while fetch is not valid.
    p_invalid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !ras_empty) |=> (!ras_empty && $stable(ras_top)));

endmodule

// File: tb/nextpc_predictor_tb.sv
module nextpc_predictor_tb_top;

    localparam int XLEN = 32;
    localparam int HB   = 6;
    localparam int BB   = 4;
    localparam int RD   = 4;
    localparam int NDIR = 1 << HB;
    localparam int NBTB = 1 << BB;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_valid = 1'b0;
    logic [XLEN-1:0] fetch_pc = '0;
    logic            is_call = 1'b0;
    logic            is_ret = 1'b0;
    logic [XLEN-1:0] call_ret_addr = '0;
    logic            upd_valid = 1'b0;
    logic [XLEN-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [XLEN-1:0] upd_target = '0;
    logic [XLEN-1:0] pred_next_pc;
    logic            pred_taken;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nextpc_predictor #(
        .XLEN(XLEN), .HIST_BITS(HB), .BTB_IDX_BITS(BB), .RAS_DEPTH(RD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .is_call(is_call), .is_ret(is_ret), .call_ret_addr(call_ret_addr),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .pred_next_pc(pred_next_pc), .pred_taken(pred_taken)
    );

    // Reference model state.
    int              m_ctr  [NDIR];
    logic [HB-1:0]   m_ghr;
    bit              m_bv   [NBTB];
    logic [XLEN-1:0] m_bpc  [NBTB];
    logic [XLEN-1:0] m_btgt [NBTB];
    logic [XLEN-1:0] m_ras  [RD];
    int              m_top;
    int              m_cnt;

    task automatic model_reset();
        for (int i = 0; i < NDIR; i++) m_ctr[i] = 1;
        for (int i = 0; i < NBTB; i++) m_bv[i] = 1'b0;
        m_ghr = '0;
        m_top = 0;
        m_cnt = 0;
    endtask

    task automatic model_predict(input logic [XLEN-1:0] pc, input logic call, input logic ret,
                                 output logic [XLEN-1:0] npc, output logic tk);
        int di;
        int bi;
        logic dir;
        di  = int'(pc[HB+1:2] ^ m_ghr);
        bi  = int'(pc[BB+1:2]);
        dir = (m_ctr[di] >= 2);
        if (ret && !call) begin
            if (m_cnt > 0) begin
                npc = m_ras[(m_top + RD - 1) % RD];
                tk  = 1'b1;
            end else begin
                npc = pc + 4;
                tk  = 1'b0;
            end
        end else begin
            tk  = dir;
            npc = (dir && m_bv[bi] && m_bpc[bi][XLEN-1:BB+2] == pc[XLEN-1:BB+2])
                  ? m_btgt[bi] : pc + 4;
        end
    endtask

    task automatic expect_pred(input logic [XLEN-1:0] exp_pc, input logic exp_tk, input string tag);
        checks++;
        if (pred_next_pc !== exp_pc || pred_taken !== exp_tk) begin
            errors++;
            $display("FAIL %s: got pc=%08h taken=%0b expected pc=%08h taken=%0b",
                     tag, pred_next_pc, pred_taken, exp_pc, exp_tk);
        end
    endtask

    // One cycle: drive at the falling edge, optionally compare with the model,
    // then advance the model at the rising edge.
    task automatic step(input logic fv, input logic [XLEN-1:0] fpc, input logic call,
                        input logic ret, input logic [XLEN-1:0] raddr,
                        input logic uv, input logic [XLEN-1:0] upc, input logic ut,
                        input logic [XLEN-1:0] utgt, input bit chk, input string tag);
        logic [XLEN-1:0] enpc;
        logic etk;
        int ui;
        int bi;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fpc; is_call = call; is_ret = ret; call_ret_addr = raddr;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
        #1;
        if (chk) begin
            model_predict(fpc, call, ret, enpc, etk);
            expect_pred(enpc, etk, tag);
        end
        @(posedge clk);
        if (uv) begin
            ui = int'(upc[HB+1:2] ^ m_ghr);
            if (ut && m_ctr[ui] < 3) m_ctr[ui]++;
            if (!ut && m_ctr[ui] > 0) m_ctr[ui]--;
            m_ghr = {m_ghr[HB-2:0], ut};
            if (ut) begin
                bi = int'(upc[BB+1:2]);
                m_bv[bi] = 1'b1; m_bpc[bi] = upc; m_btgt[bi] = utgt;
            end
        end
        if (fv && call) begin
            m_ras[m_top] = raddr;
            m_top = (m_top + 1) % RD;
            if (m_cnt < RD) m_cnt++;
        end else if (fv && ret && m_cnt > 0) begin
            m_top = (m_top + RD - 1) % RD;
            m_cnt--;
        end
        #1;
        fetch_valid = 0; is_call = 0; is_ret = 0; upd_valid = 0; upd_taken = 0;
    endtask

    task automatic upd(input logic [XLEN-1:0] pc, input logic t, input logic [XLEN-1:0] tgt);
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, pc, t, tgt, 1'b0, "");
    endtask

    task automatic probe(input logic [XLEN-1:0] pc, input string tag);
        step(1'b1, pc, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, tag);
    endtask

    task automatic probe_hard(input logic [XLEN-1:0] pc, input logic call, input logic ret,
                              input logic fv, input logic [XLEN-1:0] epc, input logic etk,
                              input string tag);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; is_call = call; is_ret = ret;
        #1;
        expect_pred(epc, etk, tag);
        fetch_valid = 0; is_call = 0; is_ret = 0;
    endtask

    task automatic t_reset();
        probe_hard(32'h0000_0000, 0, 0, 1, 32'h0000_0004, 0, "R1 reset pc0");
        probe_hard(32'h0000_1234, 0, 0, 1, 32'h0000_1238, 0, "R1 reset pc1");
        probe_hard(32'h0000_4000, 0, 1, 1, 32'h0000_4004, 0, "R1 reset ret");
    endtask

    task automatic t_loop();
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 8; k++) begin
                step(1'b1, 32'h0000_0334, 1'b0, 1'b0, '0,
                     1'b1, 32'h0000_0334, (k != 7), 32'h0000_0300, 1'b1, "R3 R5 loop");
            end
        end
        for (int k = 0; k < 10; k++) begin
            step(1'b1, 32'h0000_0478, 1'b0, 1'b0, '0,
                 1'b1, 32'h0000_0478, k[0], 32'h0000_0500, 1'b1, "R2 R3 alternate");
        end
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 20; k++) upd(32'h0000_0200, 1'b1, 32'h0000_0800);
        probe_hard(32'h0000_0200, 0, 0, 1, 32'h0000_0800, 1, "R2 R5 strong taken");
        for (int k = 0; k < 2; k++) begin
            upd(32'h0000_0200, 1'b0, 32'h0000_0800);
            probe(32'h0000_0200, "R2 step down");
        end
        for (int k = 0; k < 20; k++) upd(32'h0000_0600, 1'b0, 32'h0000_0900);
        probe_hard(32'h0000_0600, 0, 0, 1, 32'h0000_0604, 0, "R2 strong not taken");
        for (int k = 0; k < 3; k++) begin
            upd(32'h0000_0600, 1'b1, 32'h0000_0900);
            probe(32'h0000_0600, "R2 step up");
            probe(32'h0000_0200, "R3 history mix");
        end
    endtask

    task automatic t_btb();
        for (int k = 0; k < 12; k++) upd(32'h0000_1044, 1'b1, 32'h0000_7000);
        probe_hard(32'h0000_1044, 0, 0, 1, 32'h0000_7000, 1, "R4 fill hit");
        upd(32'h0000_2044, 1'b1, 32'h0000_7100);
        probe_hard(32'h0000_1044, 0, 0, 1, 32'h0000_1048, 1, "R4 R5 tag miss");
        probe_hard(32'h0000_2044, 0, 0, 1, 32'h0000_7100, 1, "R4 alias replace");
        upd(32'h0000_1044, 1'b0, 32'h0000_7200);
        for (int k = 0; k < 6; k++) upd(32'h0000_0108, 1'b1, 32'h0000_7300);
        probe_hard(32'h0000_2044, 0, 0, 1, 32'h0000_7100, 1, "R4 no fill on not taken");
        probe(32'h0000_0108, "R4 R5 model");
    endtask

    task automatic t_ras();
        step(1'b1, 32'h0000_3000, 1'b1, 1'b0, 32'h0000_3004, 1'b0, '0, 1'b0, '0, 1'b0, "");
        step(1'b1, 32'h0000_3100, 1'b1, 1'b0, 32'h0000_3104, 1'b0, '0, 1'b0, '0, 1'b0, "");
        step(1'b1, 32'h0000_3200, 1'b1, 1'b1, 32'h0000_3204, 1'b0, '0, 1'b0, '0, 1'b1,
             "R6 call wins");
        probe_hard(32'h0000_3800, 0, 1, 1, 32'h0000_3204, 1, "R6 pop3");
        step(1'b1, 32'h0000_3800, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b0, "");
        probe_hard(32'h0000_3800, 0, 1, 1, 32'h0000_3104, 1, "R6 pop2");
        step(1'b1, 32'h0000_3800, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b0, "");
        probe_hard(32'h0000_3800, 0, 1, 1, 32'h0000_3004, 1, "R6 pop1");
        step(1'b1, 32'h0000_3800, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b0, "");
        probe_hard(32'h0000_3800, 0, 1, 1, 32'h0000_3804, 0, "R8 empty");
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 32'h0000_5000, 1'b1, 1'b0, 32'h0000_5000 + 32'(k * 16),
                 1'b0, '0, 1'b0, '0, 1'b0, "");
        end
        for (int k = 5; k >= 2; k--) begin
            probe_hard(32'h0000_5800, 0, 1, 1, 32'h0000_5000 + 32'(k * 16), 1, "R7 overflow order");
            step(1'b1, 32'h0000_5800, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b0, "");
        end
        probe_hard(32'h0000_5800, 0, 1, 1, 32'h0000_5804, 0, "R7 R8 drained");
        step(1'b1, 32'h0000_5800, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b1, "R8 pop empty");
        step(1'b1, 32'h0000_5900, 1'b1, 1'b0, 32'h0000_5a00, 1'b0, '0, 1'b0, '0, 1'b0, "");
        probe_hard(32'h0000_5800, 0, 1, 1, 32'h0000_5a00, 1, "R8 stays empty after pop");
        step(1'b1, 32'h0000_5800, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b0, "");
    endtask

    task automatic t_invalid();
        step(1'b1, 32'h0000_6000, 1'b1, 1'b0, 32'h0000_6004, 1'b0, '0, 1'b0, '0, 1'b0, "");
        step(1'b0, 32'h0000_6100, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b1, "R9 ret invalid");
        step(1'b0, 32'h0000_6100, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b1, "R9 ret invalid again");
        step(1'b0, 32'h0000_6200, 1'b1, 1'b0, 32'h0000_6666, 1'b0, '0, 1'b0, '0, 1'b0, "");
        probe_hard(32'h0000_6100, 0, 1, 0, 32'h0000_6004, 1, "R9 no pop no push");
        step(1'b1, 32'h0000_6100, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, '0, 1'b0, "");
        probe_hard(32'h0000_6100, 0, 1, 1, 32'h0000_6104, 0, "R9 single entry");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_loop();
        t_saturate();
        t_btb();
        t_ras();
        t_overflow();
        t_invalid();
        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule